// File: doc/BRIEF.md
# Buffered Flash Program Sequencer

This block sits on the host side of a parallel flash device and carries out one buffered program operation for each request. A requester gives it a block address, a start address inside that block, a transfer count and a stream of data words. The block checks that the whole transfer fits inside the block. It then drives the flash bus through a fixed series of command, data and status cycles, and reports one outcome: done, timeout or error.

The series runs as follows. The block asks for the device write buffer and polls until the buffer is available or a poll limit runs out. It writes the count, then the data words, then the confirm code. It polls the program engine until the engine is ready. A sequence error reported by the device is cleared, and the operation always ends by putting the device back into read-array mode. Every bus cycle has a setup cycle, a strobe that lasts a parameter number of clocks, and a hold cycle. Address and data do not change during that time.

Top module: `flash_bufprog_seq`

## Requirements
- R1: While reset is high and in the cycle after it falls, busy, done, timeout, error and data_take are 0, fl_ce_n, fl_we_n and fl_oe_n are 1, and fl_dq_oe is 0.
- R2: Every bus cycle holds fl_ce_n low together with exactly one of fl_we_n (write) or fl_oe_n (read) for STROBE_CYC consecutive clocks. fl_we_n and fl_oe_n are never low together, and fl_addr and fl_dq_out stay stable while fl_ce_n is low. During reads fl_dq_oe is 0.
- R3: An accepted request first writes E8h to the block address and then reads the extended status. Bit 7 = 1 in that status means the write buffer is available.
- R4: When extended status bit 7 is 0, the block writes E8h again and reads again. After poll_limit reads that all show bit 7 = 0 (a poll_limit of 0 counts as 1), it writes FFh to the block address and pulses timeout.
- R5: Once the buffer is available, the block writes count_n to the block address. A count_n of 0 means one word.
- R6: The block then makes count_n+1 data writes, to start_address+i with word i of the stream. data_take pulses once for each word consumed, and the next word must be on wr_data by the next data write.
- R7: After the data the block writes D0h to the block address. It then reads the status repeatedly until bit 7 = 1.
- R8: A request is refused when the bits of start_addr above the low BLK_OFS_W bits differ from those of blk_addr, or when the low BLK_OFS_W bits of start_addr plus count_n reach 2^BLK_OFS_W. A refused request makes no bus cycle, pulses error one cycle after start, and leaves busy at 0.
- R9: When the final status has bit 7 = 1 and bit 4 = 0, the block writes FFh to the block address and pulses done.
- R10: When the final status has bit 7 = 1 and bit 4 = 1 (sequence error), the block writes 50h and then FFh to the block address, and pulses error.
- R11: busy is 1 from the cycle after an accepted start until the outcome pulse. Exactly one of done, timeout or error pulses, for one cycle, once for each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| blk_addr | input | ADDR_W | Target block address for commands |
| start_addr | input | ADDR_W | Device address of the first data word |
| count_n | input | CNT_W | Word count minus one |
| poll_limit | input | POLL_W | Maximum buffer-availability reads |
| wr_data | input | DATA_W | Current data word of the stream |
| data_take | output | 1 | Pulse: current word consumed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Pulse: program completed |
| timeout | output | 1 | Pulse: buffer never became available |
| error | output | 1 | Pulse: request refused or sequence error |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | DATA_W | Flash data driven on writes |
| fl_dq_in | input | DATA_W | Flash data returned on reads |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The bench targets the edges of the range check. A start word that ends exactly on the last address of the block must be accepted, and one that goes one word past it must be refused. A design with an off-by-one in the carry test would refuse the first case or program across the boundary in the second. Other runs use count 0 and count 15, and a device whose buffer stays busy for several polls. A wrong address step or an N versus N+1 slip then shows up as a missing or extra bus write against the scoreboard. Further runs use poll limits of 0 and 3 and a final status with a sequence error. A design that lost the timeout, the clear command or the final read-array write would leave the expected writes unmatched or report the wrong outcome.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [7:0] CMD_BUF_REQ   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
  localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam int         ST_READY_BIT  = 7;
  localparam int         ST_SEQERR_BIT = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_XCMD, S_XRD, S_CNT, S_DAT, S_CFM, S_SRD, S_CLR, S_FF
  } seq_state_t;

  typedef enum logic [1:0] {OC_OK, OC_TMO, OC_ERR} outcome_t;

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_HOLD} bus_state_t;
endpackage

// File: rtl/flash_range_check.sv
module flash_range_check #(
  parameter int ADDR_W    = 12,
  parameter int BLK_OFS_W = 6,
  parameter int CNT_W     = 4
) (
  input  logic [ADDR_W-1:0] blk_addr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  count_n,
  output logic              fits
);
  localparam int SUM_W = (BLK_OFS_W > CNT_W ? BLK_OFS_W : CNT_W) + 1;

  logic             same_blk;
  logic [SUM_W-1:0] last_ofs;

  always_comb begin
    same_blk = (start_addr[ADDR_W-1:BLK_OFS_W] == blk_addr[ADDR_W-1:BLK_OFS_W]);
    last_ofs = SUM_W'(start_addr[BLK_OFS_W-1:0]) + SUM_W'(count_n);
    fits     = same_blk && (last_ofs < SUM_W'(2**BLK_OFS_W));
  end
endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_rd,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_data,
  output logic              cyc_done,
  output logic              st_ready,
  output logic              st_seqerr,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dq_out,
  input  logic [DATA_W-1:0] fl_dq_in,
  output logic              fl_dq_oe,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);
  localparam int CW = $clog2(STROBE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STROBE_CYC - 1);

  bus_state_t    bst;
  logic          rd_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bst <= B_IDLE; rd_q <= 1'b0; cnt <= '0;
      fl_addr <= '0; fl_dq_out <= '0; fl_dq_oe <= 1'b0;
      fl_ce_n <= 1'b1; fl_we_n <= 1'b1; fl_oe_n <= 1'b1;
      cyc_done <= 1'b0; st_ready <= 1'b0; st_seqerr <= 1'b0;
    end else begin
      cyc_done <= 1'b0;
      case (bst)
        B_IDLE: if (go) begin
          fl_addr   <= go_addr;
          fl_dq_out <= go_data;
          rd_q      <= go_rd;
          fl_dq_oe  <= !go_rd;
          bst       <= B_SETUP;
        end
        B_SETUP: begin
          fl_ce_n <= 1'b0;
          if (rd_q) fl_oe_n <= 1'b0;
          else      fl_we_n <= 1'b0;
          cnt <= '0;
          bst <= B_STROBE;
        end
        B_STROBE: begin
          if (cnt == LAST) begin
            fl_ce_n <= 1'b1; fl_we_n <= 1'b1; fl_oe_n <= 1'b1;
            if (rd_q) begin
              st_ready  <= fl_dq_in[ST_READY_BIT];
              st_seqerr <= fl_dq_in[ST_SEQERR_BIT];
            end
            bst <= B_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          fl_dq_oe <= 1'b0;
          cyc_done <= 1'b1;
          bst      <= B_IDLE;
        end
      endcase
    end
  end

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n));
  a_r2_ce_with_strobe: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);
  a_r2_bus_stable: assert property (@(posedge clk) disable iff (rst)
    (!fl_ce_n && $past(!fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));
  a_r2_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_dq_oe);
endmodule

// File: rtl/flash_bufprog_seq.sv
module flash_bufprog_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 4,
  parameter int BLK_OFS_W  = 6,
  parameter int POLL_W     = 8,
  parameter int STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] blk_addr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  count_n,
  input  logic [POLL_W-1:0] poll_limit,
  input  logic [DATA_W-1:0] wr_data,
  output logic              data_take,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              error,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dq_out,
  input  logic [DATA_W-1:0] fl_dq_in,
  output logic              fl_dq_oe,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);
  seq_state_t        st;
  outcome_t          oc;
  logic              fits, go, op_rd, eng_done, st_ready, st_seqerr;
  logic [ADDR_W-1:0] op_addr, blk_q, addr_q;
  logic [DATA_W-1:0] op_data;
  logic [CNT_W-1:0]  n_q, idx;
  logic [POLL_W-1:0] polls;

  flash_range_check #(.ADDR_W(ADDR_W), .BLK_OFS_W(BLK_OFS_W), .CNT_W(CNT_W)) u_chk (
    .blk_addr(blk_addr), .start_addr(start_addr), .count_n(count_n), .fits(fits));

  flash_bus_cycle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)) u_bus (
    .clk(clk), .rst(rst), .go(go), .go_rd(op_rd), .go_addr(op_addr), .go_data(op_data),
    .cyc_done(eng_done), .st_ready(st_ready), .st_seqerr(st_seqerr),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_in(fl_dq_in), .fl_dq_oe(fl_dq_oe),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; oc <= OC_OK; go <= 1'b0; op_rd <= 1'b0;
      op_addr <= '0; op_data <= '0; blk_q <= '0; addr_q <= '0;
      n_q <= '0; idx <= '0; polls <= '0;
      done <= 1'b0; timeout <= 1'b0; error <= 1'b0; data_take <= 1'b0;
    end else begin
      go <= 1'b0; done <= 1'b0; timeout <= 1'b0; error <= 1'b0; data_take <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (!fits) begin
            error <= 1'b1;
          end else begin
            blk_q <= blk_addr; addr_q <= start_addr; n_q <= count_n;
            polls <= '0; idx <= '0;
            go <= 1'b1; op_rd <= 1'b0; op_addr <= blk_addr;
            op_data <= DATA_W'(CMD_BUF_REQ);
            st <= S_XCMD;
          end
        end
        S_XCMD: if (eng_done) begin
          go <= 1'b1; op_rd <= 1'b1; op_addr <= blk_q; st <= S_XRD;
        end
        S_XRD: if (eng_done) begin
          go <= 1'b1; op_rd <= 1'b0; op_addr <= blk_q;
          if (st_ready) begin
            op_data <= DATA_W'(n_q); st <= S_CNT;
          end else if (({1'b0, polls} + 1'b1) >= {1'b0, poll_limit}) begin
            op_data <= DATA_W'(CMD_RD_ARRAY); oc <= OC_TMO; st <= S_FF;
          end else begin
            polls <= polls + 1'b1;
            op_data <= DATA_W'(CMD_BUF_REQ); st <= S_XCMD;
          end
        end
        S_CNT: if (eng_done) begin
          go <= 1'b1; op_rd <= 1'b0; op_addr <= addr_q; op_data <= wr_data;
          data_take <= 1'b1; st <= S_DAT;
        end
        S_DAT: if (eng_done) begin
          go <= 1'b1; op_rd <= 1'b0;
          if (idx == n_q) begin
            op_addr <= blk_q; op_data <= DATA_W'(CMD_CONFIRM); st <= S_CFM;
          end else begin
            idx <= idx + 1'b1; addr_q <= addr_q + 1'b1;
            op_addr <= addr_q + 1'b1; op_data <= wr_data; data_take <= 1'b1;
          end
        end
        S_CFM: if (eng_done) begin
          go <= 1'b1; op_rd <= 1'b1; op_addr <= blk_q; st <= S_SRD;
        end
        S_SRD: if (eng_done) begin
          go <= 1'b1; op_addr <= blk_q;
          if (!st_ready) begin
            op_rd <= 1'b1;
          end else if (st_seqerr) begin
            op_rd <= 1'b0; op_data <= DATA_W'(CMD_CLR_STAT); oc <= OC_ERR; st <= S_CLR;
          end else begin
            op_rd <= 1'b0; op_data <= DATA_W'(CMD_RD_ARRAY); oc <= OC_OK; st <= S_FF;
          end
        end
        S_CLR: if (eng_done) begin
          go <= 1'b1; op_rd <= 1'b0; op_addr <= blk_q;
          op_data <= DATA_W'(CMD_RD_ARRAY); st <= S_FF;
        end
        default: if (eng_done) begin
          case (oc)
            OC_TMO:  timeout <= 1'b1;
            OC_ERR:  error   <= 1'b1;
            default: done    <= 1'b1;
          endcase
          st <= S_IDLE;
        end
      endcase
    end
  end

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, timeout, error}));
  a_r8_refuse: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !fits) |=> (error && !busy && fl_ce_n));
  a_r6_take_in_data: assert property (@(posedge clk) disable iff (rst)
    data_take |-> (st == S_DAT));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> fl_ce_n);
endmodule

// File: tb/flash_bufprog_seq_test.sv
`timescale 1ns/1ps
module flash_bufprog_seq_test;
  localparam int AW = 12, DW = 16, STROBE = 2;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [AW-1:0] blk_addr = '0, start_addr = '0;
  logic [3:0]    count_n = '0;
  logic [7:0]    poll_limit = 8'd1;
  logic [DW-1:0] wr_data, fl_dq_out, fl_dq_in;
  logic [AW-1:0] fl_addr;
  logic data_take, busy, done, timeout, error, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  always #2 clk = ~clk;

  flash_bufprog_seq uut (
    .clk(clk), .rst(rst), .start(start), .blk_addr(blk_addr), .start_addr(start_addr),
    .count_n(count_n), .poll_limit(poll_limit), .wr_data(wr_data), .data_take(data_take),
    .busy(busy), .done(done), .timeout(timeout), .error(error), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_in(fl_dq_in), .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

  int checks = 0, errors = 0;
  logic [AW+DW-1:0] exp_q[$];
  logic [DW-1:0] dwords[17];
  int take_idx = 0, outcome = 0, out_pulses = 0;
  int xbusy = 0, sbusy = 0, phase = 0, low_cnt = 0;
  bit serr = 0;
  logic we_q = 1'b1, oe_q = 1'b1;

  assign wr_data = dwords[take_idx > 16 ? 16 : take_idx];

  always_comb begin
    fl_dq_in = '0;
    if (phase == 1)      fl_dq_in = (xbusy > 0) ? 16'h0000 : 16'h0080;
    else if (phase == 2) fl_dq_in = (sbusy > 0) ? 16'h0000 : (serr ? 16'h0090 : 16'h0080);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: flash model, strobe checks and scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (!fl_we_n || !fl_oe_n) begin
        low_cnt++;
        chk(!fl_ce_n, "R2", "ce_n low during strobe", fl_ce_n, 0);
      end
      if (!fl_oe_n) chk(!fl_dq_oe, "R2", "no drive on read", fl_dq_oe, 0);
      if ((!we_q && fl_we_n) || (!oe_q && fl_oe_n)) begin
        chk(low_cnt == STROBE, "R2", "strobe width", low_cnt, STROBE);
        low_cnt = 0;
      end
      if (!we_q && fl_we_n) begin
        if (exp_q.size() == 0) chk(0, "R3", "unexpected write", {fl_addr, fl_dq_out}, 0);
        else begin
          logic [AW+DW-1:0] e;
          e = exp_q.pop_front();
          chk(e == {fl_addr, fl_dq_out}, "R6", "bus write", {fl_addr, fl_dq_out}, e);
        end
        if (fl_dq_out == 16'h00E8) phase = 1;
        else if (fl_dq_out == 16'h00D0) phase = 2;
      end
      if (!oe_q && fl_oe_n) begin
        if (phase == 1 && xbusy > 0) xbusy--;
        else if (phase == 2 && sbusy > 0) sbusy--;
      end
      if (data_take) take_idx++;
      if (done || timeout || error) begin
        out_pulses++;
        outcome = done ? 1 : timeout ? 2 : 3;
      end
    end
    we_q = fl_we_n; oe_q = fl_oe_n;
  end

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_q.push_back({a, d});
  endtask

  // driver: exp_out 1=done 2=timeout 3=error
  task automatic run_req(input logic [AW-1:0] blk, input logic [AW-1:0] sa, input logic [3:0] n,
                         input int xb, input int sb, input bit se, input logic [7:0] lim,
                         input bit refuse, input int exp_out, input string req);
    int wait_cyc;
    int e8;
    for (int i = 0; i < 17; i++) dwords[i] = 16'hA500 + 16'(i * 3) + 16'(n);
    if (!refuse) begin
      e8 = (exp_out == 2) ? ((lim == 0) ? 1 : int'(lim)) : xb + 1;
      for (int i = 0; i < e8; i++) push(blk, 16'h00E8);
      if (exp_out != 2) begin
        push(blk, 16'(n));
        for (int i = 0; i <= int'(n); i++) push(sa + AW'(i), dwords[i]);
        push(blk, 16'h00D0);
        if (se) push(blk, 16'h0050);
      end
      push(blk, 16'h00FF);
    end
    @(negedge clk);
    xbusy = xb; sbusy = sb; serr = se; phase = 0; take_idx = 0;
    outcome = 0; out_pulses = 0;
    blk_addr = blk; start_addr = sa; count_n = n; poll_limit = lim; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    if (refuse) begin
      chk(busy == 1'b0, "R8", "busy after refused start", busy, 0);
      chk(error == 1'b1, "R8", "error one cycle after start", error, 1);
    end else
      chk(busy == 1'b1, "R11", "busy after start", busy, 1);
    wait_cyc = 0;
    while (out_pulses == 0 && wait_cyc < 5000) begin
      @(posedge clk); wait_cyc++;
    end
    chk(wait_cyc < 5000, "R11", "watchdog", wait_cyc, 0);
    repeat (4) @(posedge clk);
    #1;
    chk(outcome == exp_out, req, "outcome", outcome, exp_out);
    chk(out_pulses == 1, "R11", "outcome pulse count", out_pulses, 1);
    chk(exp_q.size() == 0, req, "writes left unmatched", exp_q.size(), 0);
    chk(busy == 1'b0, "R11", "busy after outcome", busy, 0);
    chk(take_idx == ((refuse || exp_out == 2) ? 0 : int'(n) + 1), "R6", "words taken",
        take_idx, (refuse || exp_out == 2) ? 0 : int'(n) + 1);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({busy, done, timeout, error, data_take, fl_dq_oe} == 6'b0, "R1", "reset outputs low",
        {busy, done, timeout, error, data_take, fl_dq_oe}, 0);
    chk({fl_ce_n, fl_we_n, fl_oe_n} == 3'b111, "R1", "reset strobes high",
        {fl_ce_n, fl_we_n, fl_oe_n}, 7);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!busy && fl_ce_n && fl_we_n && fl_oe_n, "R1", "after reset", busy, 0);

    run_req(12'h0C0, 12'h0C4, 4'd3, 0, 0, 0, 8'd4, 0, 1, "R9");   // R3 R5 R7 R9 plain
    run_req(12'h100, 12'h100, 4'd0, 2, 3, 0, 8'd5, 0, 1, "R7");   // R4 R7 count 0, polls
    run_req(12'h040, 12'h040, 4'd15, 0, 1, 0, 8'd1, 0, 1, "R6");  // R6 max count
    run_req(12'h200, 12'h23C, 4'd3, 0, 0, 0, 8'd2, 0, 1, "R8");   // R8 ends on last word
    run_req(12'h200, 12'h23C, 4'd4, 0, 0, 0, 8'd2, 1, 3, "R8");   // R8 crosses boundary
    run_req(12'h200, 12'h280, 4'd1, 0, 0, 0, 8'd2, 1, 3, "R8");   // R8 other block
    run_req(12'h300, 12'h310, 4'd2, 100, 0, 0, 8'd3, 0, 2, "R4"); // R4 timeout
    run_req(12'h300, 12'h310, 4'd2, 100, 0, 0, 8'd0, 0, 2, "R4"); // R4 limit 0 as 1
    run_req(12'h380, 12'h388, 4'd1, 1, 2, 1, 8'd4, 0, 3, "R10");  // R10 sequence error
    run_req(12'h0C0, 12'h0C1, 4'd5, 0, 0, 0, 8'd1, 0, 1, "R5");   // R5 recovery run

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule